// File: doc/BRIEF.md
# RAM Controller Interrupt and Control Register Block

This block is the 32-bit register slave of an on-chip RAM controller. Software uses it to set error-response and ECC control bits, to hold fault-injection data and a fault-injection count, to read the encoded RAM size, and to manage a group of eleven interrupt sources. Each source has a status bit and a mask bit. The block drives one level-sensitive interrupt line.

Status bits are raised by a pulse on a set input. Software clears them by writing ones to the status register. The mask cannot be written directly. Writing ones to the enable register unmasks sources, and writing ones to the disable register masks them. The block also maps first-failing address and syndrome capture registers. Software can only read them. The RAM data path does not feed them here, so they read as zero.

The RAM size in bytes is a parameter. Any value other than 64 KiB, 128 KiB, 256 KiB, 512 KiB or 1 MiB stops elaboration. Accesses are whole aligned 32-bit words. A write takes effect at the clock edge where `wrEn` is high. Read data is a combinational function of `addr` and the current register state.

Top module: `ramctl_irq_regs`

## Requirements
- R1: After reset the registers hold these values:
  - status (0x4) reads 0x000.
  - mask (0x8) reads 0x7FF.
  - error control (0x0) reads 0xF.
  - power-ready debug (0x84) reads 0xFFFF.
  - `irqOut` is low.
- R2: `irqOut` is high exactly when some status bit is set and its mask bit is clear. It follows the register state in the same cycle.
- R3: A write to 0xC clears every mask bit written as one. A write to 0x10 sets every mask bit written as one. A direct write to 0x8 leaves the mask unchanged. Offsets 0xC and 0x10 always read zero.
- R4: A write to 0x4 clears every status bit [10:0] written as one and leaves the others. Status bits [31:11] read zero.
- R5: A high `statusSet` bit sets the matching status bit at the next edge. If the same edge also carries a write-one-to-clear of that bit, the bit ends set.
- R6: The writable control registers keep only their own bits, and all other bits read zero:
  - error control at 0x0: bits [3:0].
  - ECC control at 0x14: bits [2:0].
  - fault-injection syndrome at 0x5C: bits [15:0].
  - fault-injection counter at 0x74: bits [23:0].
  - fault-injection data at 0x4C, 0x50, 0x54 and 0x58: 32 bits each.
- R7: Offset 0x80 reads the size code in bits [3:0]. The codes are 0 for 64 KiB, 1 for 128 KiB, 2 for 256 KiB, 3 for 512 KiB and 4 for 1 MiB; the default is 4. Writes to 0x80 are ignored.
- R8: These offsets ignore writes:
  - capture address registers 0x1C, 0x34 and 0x70, which read zero.
  - capture data registers 0x20–0x2C and 0x38–0x44, which read zero.
  - capture syndrome registers 0x30 and 0x48, which read zero.
  - power-ready debug 0x84, which keeps reading 0xFFFF.
- R9: Unmapped offsets and offsets whose low two address bits are nonzero read zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one 32-bit word |
| addr | input | 12 | Byte offset within the 4 KiB window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| statusSet | input | 11 | Per-source status set pulses |
| irqOut | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle that:
- the mask moves only on an enable or disable write, and each of those moves the bits written.
- a set pulse always lands in status, even against a clear.
- a fully masked status never raises the interrupt.
- decoded write strobes are at most one-hot, and a misaligned access produces none.

Only the bench scenarios show the read-back values: reset contents, reserved-bit masking, the size code, read-only and unmapped offsets that stay unchanged, and a long random mix of set pulses, clears, enables and disables compared against a reference model.

// File: rtl/ramctl_pkg.sv
package ramctl_pkg;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_ERR, SEL_STAT, SEL_MASK, SEL_ECC,
    SEL_FID0, SEL_FID1, SEL_FID2, SEL_FID3, SEL_FISY,
    SEL_FICNT, SEL_IMPL, SEL_PRDY
  } readSelT;

  typedef struct packed {
    logic       errWr;
    logic       statWr;
    logic       maskClr;
    logic       maskSet;
    logic       eccWr;
    logic       fiSyWr;
    logic       fiCntWr;
    logic [3:0] fiDataWr;
  } wrStrobeT;

  function automatic logic [3:0] sizeCode(input longint unsigned bytes);
    case (bytes)
      64'd65536:   return 4'd0;
      64'd131072:  return 4'd1;
      64'd262144:  return 4'd2;
      64'd524288:  return 4'd3;
      64'd1048576: return 4'd4;
      default:     return 4'hF;
    endcase
  endfunction

endpackage

// File: rtl/ramctl_ctrl.sv
module ramctl_ctrl
  import ramctl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output wrStrobeT          strb,
  output readSelT           readSel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    readSel = SEL_ZERO;
    if (aligned) begin
      case (int'(wordIdx))
        'h00: readSel = SEL_ERR;
        'h01: readSel = SEL_STAT;
        'h02: readSel = SEL_MASK;
        'h05: readSel = SEL_ECC;
        'h13: readSel = SEL_FID0;
        'h14: readSel = SEL_FID1;
        'h15: readSel = SEL_FID2;
        'h16: readSel = SEL_FID3;
        'h17: readSel = SEL_FISY;
        'h1D: readSel = SEL_FICNT;
        'h20: readSel = SEL_IMPL;
        'h21: readSel = SEL_PRDY;
        default: readSel = SEL_ZERO;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    if (wrEn && aligned) begin
      case (int'(wordIdx))
        'h00: strb.errWr       = 1'b1;
        'h01: strb.statWr      = 1'b1;
        'h03: strb.maskClr     = 1'b1;
        'h04: strb.maskSet     = 1'b1;
        'h05: strb.eccWr       = 1'b1;
        'h13: strb.fiDataWr[0] = 1'b1;
        'h14: strb.fiDataWr[1] = 1'b1;
        'h15: strb.fiDataWr[2] = 1'b1;
        'h16: strb.fiDataWr[3] = 1'b1;
        'h17: strb.fiSyWr      = 1'b1;
        'h1D: strb.fiCntWr     = 1'b1;
        default: strb = '0;
      endcase
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R9
  AST_MISALIGN_NOWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (addr[1:0] != 2'b00) |-> (strb == '0)); // R9

endmodule

// File: rtl/ramctl_dp.sv
module ramctl_dp
  import ramctl_pkg::*;
#(
  parameter int          N_SRC     = 11,
  parameter logic [3:0]  SIZE_CODE = 4'd4
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobeT         strb,
  input  readSelT          readSel,
  input  logic [31:0]      wrData,
  input  logic [N_SRC-1:0] statusSet,
  output logic [31:0]      rdData,
  output logic             irqOut
);
  localparam int ERR_W   = 4;
  localparam int ECC_W   = 3;
  localparam int FISY_W  = 16;
  localparam int FICNT_W = 24;
  localparam int N_FID   = 4;
  localparam logic [15:0] PRDY_VAL = 16'hFFFF;

  logic [ERR_W-1:0]   errQ;
  logic [N_SRC-1:0]   statusQ;
  logic [N_SRC-1:0]   maskQ;
  logic [ECC_W-1:0]   eccQ;
  logic [FISY_W-1:0]  fiSyQ;
  logic [FICNT_W-1:0] fiCntQ;
  logic [31:0]        fiDataQ [N_FID];

  logic [N_SRC-1:0] clrBits;
  assign clrBits = strb.statWr ? wrData[N_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ    <= '1;
      statusQ <= '0;
      maskQ   <= '1;
      eccQ    <= '0;
      fiSyQ   <= '0;
      fiCntQ  <= '0;
    end else begin
      statusQ <= (statusQ & ~clrBits) | statusSet;
      if (strb.maskClr) maskQ <= maskQ & ~wrData[N_SRC-1:0];
      else if (strb.maskSet) maskQ <= maskQ | wrData[N_SRC-1:0];
      if (strb.errWr)   errQ   <= wrData[ERR_W-1:0];
      if (strb.eccWr)   eccQ   <= wrData[ECC_W-1:0];
      if (strb.fiSyWr)  fiSyQ  <= wrData[FISY_W-1:0];
      if (strb.fiCntWr) fiCntQ <= wrData[FICNT_W-1:0];
    end
  end

  for (genvar g = 0; g < N_FID; g++) begin : gFiData
    always_ff @(posedge clk) begin
      if (!rstN) fiDataQ[g] <= '0;
      else if (strb.fiDataWr[g]) fiDataQ[g] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (readSel)
      SEL_ERR:   rdData[ERR_W-1:0]   = errQ;
      SEL_STAT:  rdData[N_SRC-1:0]   = statusQ;
      SEL_MASK:  rdData[N_SRC-1:0]   = maskQ;
      SEL_ECC:   rdData[ECC_W-1:0]   = eccQ;
      SEL_FID0:  rdData              = fiDataQ[0];
      SEL_FID1:  rdData              = fiDataQ[1];
      SEL_FID2:  rdData              = fiDataQ[2];
      SEL_FID3:  rdData              = fiDataQ[3];
      SEL_FISY:  rdData[FISY_W-1:0]  = fiSyQ;
      SEL_FICNT: rdData[FICNT_W-1:0] = fiCntQ;
      SEL_IMPL:  rdData[3:0]         = SIZE_CODE;
      SEL_PRDY:  rdData[15:0]        = PRDY_VAL;
      default:   rdData              = '0;
    endcase
  end

  assign irqOut = |(statusQ & ~maskQ);

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.maskClr || strb.maskSet) |=> $stable(maskQ)); // R3
  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskClr |=> ((maskQ & $past(wrData[N_SRC-1:0])) == '0)); // R3
  AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskSet |=> ((maskQ & $past(wrData[N_SRC-1:0])) == $past(wrData[N_SRC-1:0]))); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|statusSet) |=> ((statusQ & $past(statusSet)) == $past(statusSet))); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statWr && statusSet == '0) |=> ((statusQ & $past(wrData[N_SRC-1:0])) == '0)); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !irqOut); // R2

endmodule

// File: rtl/ramctl_irq_regs.sv
module ramctl_irq_regs
  import ramctl_pkg::*;
#(
  parameter longint unsigned RAM_BYTES = 64'd1048576,
  parameter int              ADDR_W    = 12,
  parameter int              N_SRC     = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [N_SRC-1:0]  statusSet,
  output logic              irqOut
);
  localparam logic [3:0] SIZE_CODE = sizeCode(RAM_BYTES);

  if (SIZE_CODE == 4'hF) begin : gBadSize
    $error("ramctl_irq_regs: RAM_BYTES is not a supported size");
  end

  wrStrobeT strb;
  readSelT  readSel;

  ramctl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .strb    (strb),
    .readSel (readSel)
  );

  ramctl_dp #(.N_SRC(N_SRC), .SIZE_CODE(SIZE_CODE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .readSel   (readSel),
    .wrData    (wrData),
    .statusSet (statusSet),
    .rdData    (rdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/sim_ramctl_irq_regs.sv
`timescale 1ns/1ps
module sim_ramctl_irq_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [10:0] statusSet = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ramctl_irq_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .statusSet(statusSet), .irqOut(irqOut)
  );

  // reference model
  logic [3:0]  mErr = 4'hF;
  logic [10:0] mStat = '0;
  logic [10:0] mMask = 11'h7FF;
  logic [2:0]  mEcc = '0;
  logic [15:0] mFiSy = '0;
  logic [23:0] mFiCnt = '0;
  logic [31:0] mFiD [4] = '{default: '0};

  function automatic logic [31:0] expRead(input logic [11:0] a);
    case (a)
      12'h000: return {28'd0, mErr};
      12'h004: return {21'd0, mStat};
      12'h008: return {21'd0, mMask};
      12'h014: return {29'd0, mEcc};
      12'h04C: return mFiD[0];
      12'h050: return mFiD[1];
      12'h054: return mFiD[2];
      12'h058: return mFiD[3];
      12'h05C: return {16'd0, mFiSy};
      12'h074: return {8'd0, mFiCnt};
      12'h080: return 32'd4;
      12'h084: return 32'h0000FFFF;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [11:0] a);
    case (a)
      12'h000, 12'h014, 12'h04C, 12'h050, 12'h054, 12'h058,
      12'h05C, 12'h074: return "R6";
      12'h004: return "R4";
      12'h008, 12'h00C, 12'h010: return "R3";
      12'h080: return "R7";
      12'h01C, 12'h020, 12'h030, 12'h034, 12'h048, 12'h070,
      12'h084: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic modelStep(input logic w, input logic [11:0] a,
                           input logic [31:0] d, input logic [10:0] s);
    logic [10:0] clr = '0;
    if (w) begin
      case (a)
        12'h000: mErr = d[3:0];
        12'h004: clr = d[10:0];
        12'h00C: mMask = mMask & ~d[10:0];
        12'h010: mMask = mMask | d[10:0];
        12'h014: mEcc = d[2:0];
        12'h04C: mFiD[0] = d;
        12'h050: mFiD[1] = d;
        12'h054: mFiD[2] = d;
        12'h058: mFiD[3] = d;
        12'h05C: mFiSy = d[15:0];
        12'h074: mFiCnt = d[23:0];
        default: ;
      endcase
    end
    mStat = (mStat & ~clr) | s;
  endtask

  // one clock: drive at negedge, edge, update model
  task automatic cycle(input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic [10:0] s);
    @(negedge clk);
    wrEn = w; addr = a; wrData = d; statusSet = s;
    @(posedge clk);
    modelStep(w, a, d, s);
    @(negedge clk);
    wrEn = 1'b0; statusSet = '0;
  endtask

  task automatic checkRead(input logic [11:0] a, input string tag);
    logic [31:0] e;
    addr = a; wrEn = 1'b0;
    #1;
    e = expRead(a);
    total++;
    if (rdData !== e) begin
      bad++;
      $display("FAIL %s read 0x%03h actual=0x%08h expected=0x%08h", tag, a, rdData, e);
    end
  endtask

  task automatic checkIrq(input string tag);
    logic e;
    e = |(mStat & ~mMask);
    total++;
    if (irqOut !== e) begin
      bad++;
      $display("FAIL %s irqOut actual=%0b expected=%0b", tag, irqOut, e);
    end
  endtask

  function automatic logic [11:0] pickAddr(input int unsigned r);
    case (r % 26)
      0: return 12'h000;  1: return 12'h004;  2: return 12'h008;
      3: return 12'h00C;  4: return 12'h010;  5: return 12'h014;
      6: return 12'h01C;  7: return 12'h020;  8: return 12'h030;
      9: return 12'h034;  10: return 12'h048; 11: return 12'h04C;
      12: return 12'h050; 13: return 12'h054; 14: return 12'h058;
      15: return 12'h05C; 16: return 12'h070; 17: return 12'h074;
      18: return 12'h080; 19: return 12'h084; 20: return 12'h060;
      21: return 12'hFFC; 22: return 12'h006; 23: return 12'h00C;
      24: return 12'h010; default: return 12'h004;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkRead(12'h004, "R1"); checkRead(12'h008, "R1");
    checkRead(12'h000, "R1"); checkRead(12'h084, "R1");
    checkIrq("R1");

    // R5/R2: set while masked -> no irq; then unmask
    cycle(1'b0, 12'h000, '0, 11'h001);
    checkRead(12'h004, "R5"); checkIrq("R2");
    cycle(1'b1, 12'h00C, 32'h0000_0001, '0);
    checkRead(12'h008, "R3"); checkIrq("R2");
    checkRead(12'h00C, "R3"); checkRead(12'h010, "R3");

    // R3: direct mask write ignored
    cycle(1'b1, 12'h008, 32'hFFFF_FFFF, '0);
    checkRead(12'h008, "R3");
    cycle(1'b1, 12'h010, 32'h0000_0001, '0);
    checkRead(12'h008, "R3"); checkIrq("R2");

    // R5: set wins over same-cycle clear
    cycle(1'b1, 12'h004, 32'hFFFF_FFFF, 11'h400);
    checkRead(12'h004, "R5");
    // R4: clear with reserved bits
    cycle(1'b1, 12'h004, 32'hFFFF_FFFF, '0);
    checkRead(12'h004, "R4");

    // R6 reserved bit masking
    cycle(1'b1, 12'h000, 32'hFFFF_FFF5, '0); checkRead(12'h000, "R6");
    cycle(1'b1, 12'h014, 32'hFFFF_FFFF, '0); checkRead(12'h014, "R6");
    cycle(1'b1, 12'h074, 32'hFFFF_FFFF, '0); checkRead(12'h074, "R6");
    cycle(1'b1, 12'h05C, 32'hABCD_1234, '0); checkRead(12'h05C, "R6");
    cycle(1'b1, 12'h058, 32'hDEAD_BEEF, '0); checkRead(12'h058, "R6");

    // R7, R8, R9 writes ignored
    cycle(1'b1, 12'h080, 32'hFFFF_FFFF, '0); checkRead(12'h080, "R7");
    cycle(1'b1, 12'h084, 32'h0, '0);         checkRead(12'h084, "R8");
    cycle(1'b1, 12'h01C, 32'hFFFF_FFFF, '0); checkRead(12'h01C, "R8");
    cycle(1'b1, 12'h048, 32'hFFFF_FFFF, '0); checkRead(12'h048, "R8");
    cycle(1'b1, 12'h001, 32'h0, '0);         checkRead(12'h000, "R9");
    cycle(1'b1, 12'hFFC, 32'hFFFF_FFFF, '0); checkRead(12'hFFC, "R9");
    checkRead(12'h060, "R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic [10:0] s;
      logic w;
      a = pickAddr($urandom);
      d = $urandom;
      s = (($urandom % 4) == 0) ? 11'($urandom) & 11'($urandom) : '0;
      w = ($urandom % 3) != 0;
      cycle(w, a, d, s);
      checkIrq("R2");
      checkRead(pickAddr($urandom), "");
      if (rdData !== expRead(addr)) ; // already counted
      checkRead(12'h004, "R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule